// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block sits between a byte-wide parallel port and a small register bus. An external device marks new input data with an edge on the input strobe. On the chosen edge the block copies the port pins into a held-data register and raises a status flag. The flag can also raise an interrupt request. The output strobe tells the device either that output data has been written or that input data has been taken. It does this as a timed pulse or as an interlocked level, depending on the handshake settings.

Software sees four registers:
- A mode/status register.
- The held (captured) data.
- The output byte.
- The live, synchronized port value.

The flag clears only after a two-read sequence: a read of the mode/status register that sees the flag set, then a read of the held data. The block has no pin drivers or direction logic. It takes in the pin levels and supplies the output byte, plus a level telling the pad logic that open-drain driving is selected.

Top module: `pport_hshake`

## Requirements
- R1: After reset, the mode/status register reads 0x01 and `irq` is 0. `stb_out` sits at its inactive level, which is 0, and `out_byte` is 0.
- R2: Bit 1 of the mode/status register selects the active strobe edge: 0 means falling and 1 means rising. On the active edge of `stb_in`, bit 7 (the flag) becomes 1 three clock edges after the pin change. The opposite edge changes nothing.
- R3: The active edge also copies `port_in` into the held-data register at address 1. That register keeps its value while `port_in` changes. Address 3 returns the synchronized live value of `port_in`.
- R4: The flag clears only when a read of address 0 that returns the flag at 1 is followed by a read of address 1. A read of address 1 alone leaves the flag set, and a read of address 0 while the flag is 0 does not arm the clear.
- R5: `irq` is 1 exactly when bit 6 (interrupt enable) and the flag are both 1.
- R6: With bit 4 (handshake) at 0, a write to address 2 loads `out_byte`. The same write drives `stb_out` active for exactly two clock cycles, starting right after the write edge.
- R7: Bit 0 sets the strobe polarity: 1 means `stb_out` is active high, and 0 means active low.
- R8: With bit 4 at 1, bit 3 (output direction) at 0 and bit 2 (pulsed) at 0, the block runs an interlocked input handshake. Writing this mode makes `stb_out` active. An active input edge makes it inactive. Completing the flag-clear sequence makes it active again.
- R9: With bits 4 and 3 at 1 and bit 2 at 0, the block runs an interlocked output handshake. A write to address 2 makes `stb_out` active and holds it there. The next active input edge makes it inactive.
- R10: With bits 4 and 2 at 1, `stb_out` gives a two-cycle pulse. In output handshake (bit 3 at 1) the pulse follows each write to address 2. In input handshake (bit 3 at 0) it follows completion of the flag-clear sequence.
- R11: Suppose an active input edge is detected in the same cycle as the held-data read that would complete the clear. The flag then stays 1, and that read returns the old held byte.
- R12: The flag bit is read-only. Writes to bit 7 of address 0 have no effect on it.
- R13: Register map: address 0 is mode/status, 1 is held data, 2 is the output byte, 3 is the live port. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| port_in | input | DW | Port pin levels |
| stb_in | input | 1 | Input strobe from the device |
| stb_out | output | 1 | Output strobe / acknowledge to the device |
| out_byte | output | DW | Output data byte |
| irq | output | 1 | Interrupt request |
| open_drain | output | 1 | Open-drain driving selected (bit 5) |

## Verification
The delicate overlap is an active input edge landing in the same cycle as the held-data read that would finish clearing the flag. The bench provokes it by counting the two synchronizer stages and the edge register, then issuing the read so that it is sampled on the very edge where the strobe event is detected. It judges the result by two things. The read must return the previous byte. The flag must still read as set afterwards, and a fresh status read followed by a held-data read must return the new byte and only then clear the flag.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_LATCH = 2'd1;
  localparam logic [1:0] A_OUT   = 2'd2;
  localparam logic [1:0] A_LIVE  = 2'd3;

  // Writable mode bits, bit 6 down to bit 0 of the mode/status register.
  typedef struct packed {
    logic irq_en;
    logic wire_or;
    logic hs;
    logic out_dir;
    logic pulse;
    logic rise;
    logic act_high;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{irq_en: 1'b0, wire_or: 1'b0, hs: 1'b0,
                                   out_dir: 1'b0, pulse: 1'b0, rise: 1'b0,
                                   act_high: 1'b1};
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rise_sel,
  input  logic          stb_pin,
  input  logic [DW-1:0] port_pin,
  output logic          edge_hit,
  output logic [DW-1:0] data_sync
);
  logic [STAGES-1:0] stb_chain;
  logic [DW-1:0]     dat_chain [STAGES];
  logic              stb_prev;
  logic              stb_now;

  // Synchronizer flops are not reset; they fill during the reset window.
  always_ff @(posedge clk) begin
    stb_chain[0] <= stb_pin;
    dat_chain[0] <= port_pin;
    for (int i = 1; i < STAGES; i++) begin
      stb_chain[i] <= stb_chain[i-1];
      dat_chain[i] <= dat_chain[i-1];
    end
    stb_prev <= stb_chain[STAGES-1];
  end

  assign stb_now   = stb_chain[STAGES-1];
  assign data_sync = dat_chain[STAGES-1];
  assign edge_hit  = rise_sel ? (stb_now & ~stb_prev) : (~stb_now & stb_prev);
endmodule

// File: rtl/pport_flag.sv
module pport_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic rd_ctrl,
  input  logic rd_latch,
  output logic flag,
  output logic clear_done
);
  logic armed;

  assign clear_done = rd_latch & armed & flag & ~set_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (set_evt) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (clear_done) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (rd_ctrl && flag) begin
      armed <= 1'b1;
    end
  end

  assert_set_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);
  assert_clear_needs_sequence_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> ($past(rd_latch) && $past(armed)));
endmodule

// File: rtl/pport_strobe.sv
module pport_strobe #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hs,
  input  logic out_dir,
  input  logic pulse,
  input  logic act_high,
  input  logic ctrl_wr,
  input  logic new_hs,
  input  logic new_out_dir,
  input  logic new_pulse,
  input  logic out_wr,
  input  logic edge_hit,
  input  logic clear_done,
  output logic stb_pin
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          level;
  logic          interlock;
  logic          trig;
  logic          active;

  assign interlock = hs & ~pulse;
  assign trig = (~hs & out_wr)
              | (hs & pulse & out_dir & out_wr)
              | (hs & pulse & ~out_dir & clear_done);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (trig)          cnt <= CW'(PULSE_CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
    end else if (ctrl_wr) begin
      level <= new_hs & ~new_out_dir & ~new_pulse;
    end else if (interlock && !out_dir) begin
      if (edge_hit)        level <= 1'b0;
      else if (clear_done) level <= 1'b1;
    end else if (interlock && out_dir) begin
      if (out_wr)          level <= 1'b1;
      else if (edge_hit)   level <= 1'b0;
    end
  end

  assign active  = level | (cnt != '0);
  assign stb_pin = act_high ? active : ~active;

  assert_simple_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
    (!hs && !ctrl_wr && $rose(active)) |=> active);
  assert_in_lock_release_R8: assert property (@(posedge clk) disable iff (rst)
    (interlock && !out_dir && clear_done && !edge_hit && !ctrl_wr) |=> level);
  assert_out_lock_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (interlock && out_dir && edge_hit && !out_wr && !ctrl_wr) |=> !level);
endmodule

// File: rtl/pport_hshake.sv
module pport_hshake import pport_pkg::*; #(
  parameter int DW           = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] port_in,
  input  logic          stb_in,
  output logic          stb_out,
  output logic [DW-1:0] out_byte,
  output logic          irq,
  output logic          open_drain
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] latch_q;
  logic [DW-1:0] out_q;
  logic [DW-1:0] data_sync;
  logic          edge_hit;
  logic          flag;
  logic          clear_done;
  logic          rd_ctrl, rd_latch, wr_ctrl, wr_out;

  assign rd_ctrl  = bus_rd && (bus_addr == A_CTRL);
  assign rd_latch = bus_rd && (bus_addr == A_LATCH);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_out   = bus_wr && (bus_addr == A_OUT);

  pport_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rise_sel  (ctrl_q.rise),
    .stb_pin   (stb_in),
    .port_pin  (port_in),
    .edge_hit  (edge_hit),
    .data_sync (data_sync)
  );

  pport_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .set_evt    (edge_hit),
    .rd_ctrl    (rd_ctrl),
    .rd_latch   (rd_latch),
    .flag       (flag),
    .clear_done (clear_done)
  );

  pport_strobe #(.PULSE_CYCLES(PULSE_CYCLES)) u_stb (
    .clk         (clk),
    .rst         (rst),
    .hs          (ctrl_q.hs),
    .out_dir     (ctrl_q.out_dir),
    .pulse       (ctrl_q.pulse),
    .act_high    (ctrl_q.act_high),
    .ctrl_wr     (wr_ctrl),
    .new_hs      (bus_wdata[4]),
    .new_out_dir (bus_wdata[3]),
    .new_pulse   (bus_wdata[2]),
    .out_wr      (wr_out),
    .edge_hit    (edge_hit),
    .clear_done  (clear_done),
    .stb_pin     (stb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      out_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[6:0]);
      if (wr_out)  out_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           latch_q <= '0;
    else if (edge_hit) latch_q <= data_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata <= DW'({flag, ctrl_q});
        A_LATCH: bus_rdata <= latch_q;
        A_OUT:   bus_rdata <= out_q;
        default: bus_rdata <= data_sync;
      endcase
    end
  end

  assign out_byte   = out_q;
  assign irq        = ctrl_q.irq_en & flag;
  assign open_drain = ctrl_q.wire_or;

  assert_capture_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> (latch_q == $past(data_sync)));
  assert_edge_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && rd_latch) |=> flag);
  assert_flag_not_writable_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && bus_wdata[7] && !flag && !edge_hit) |=> !flag);
  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[6]) |=> !irq);
endmodule

// File: tb/pport_hshake_test.sv
module pport_hshake_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] port_in = '0, out_byte;
  logic       stb_in = 1'b1;
  logic       stb_out, irq, open_drain;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_hshake uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_in(port_in),
    .stb_in(stb_in), .stb_out(stb_out), .out_byte(out_byte), .irq(irq),
    .open_drain(open_drain)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // Change the strobe pin and wait until the event is visible (3 edges).
  task automatic strobe(input logic v);
    @(negedge clk); stb_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_port(input logic [7:0] v);
    @(negedge clk); port_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 stb_out idle", {7'd0, stb_out}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 out_byte", out_byte, 8'h00);
    rd(2'd0, d); chk("R1 ctrl reset", d, 8'h01);
  endtask

  task automatic t_fall_capture;
    logic [7:0] d;
    set_port(8'h5A);
    strobe(1'b0);
    rd(2'd0, d); chk("R2 flag on falling edge", d, 8'h81);
    set_port(8'h33);
    rd(2'd3, d); chk("R3 live port", d, 8'h33);
    rd(2'd1, d); chk("R3 held data", d, 8'h5A);
    rd(2'd0, d); chk("R4 cleared after sequence", d, 8'h01);
    strobe(1'b1);
    rd(2'd0, d); chk("R2 opposite edge ignored", d, 8'h01);
  endtask

  task automatic t_clear_seq;
    logic [7:0] d;
    set_port(8'h11);
    strobe(1'b0);
    rd(2'd1, d); chk("R4 held read alone", d, 8'h11);
    rd(2'd0, d); chk("R4 flag kept after held-only read", d, 8'h81);
    rd(2'd1, d); chk("R4 held read completes", d, 8'h11);
    rd(2'd0, d); chk("R4 flag cleared", d, 8'h01);
    rd(2'd1, d);
    rd(2'd0, d); chk("R4 status read with flag 0 does not arm", d, 8'h01);
    strobe(1'b1);
  endtask

  task automatic t_rise;
    logic [7:0] d;
    wr(2'd0, 8'h03);
    set_port(8'h77);
    strobe(1'b0);
    rd(2'd0, d); chk("R2 falling ignored in rising mode", d, 8'h03);
    strobe(1'b1);
    rd(2'd0, d); chk("R2 flag on rising edge", d, 8'h83);
    rd(2'd1, d); chk("R3 rising capture", d, 8'h77);
    rd(2'd0, d); chk("R4 cleared rising mode", d, 8'h03);
    wr(2'd0, 8'h01);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(2'd0, 8'h41);
    chk("R5 irq low without flag", {7'd0, irq}, 8'h00);
    set_port(8'h22);
    strobe(1'b0);
    chk("R5 irq with flag and enable", {7'd0, irq}, 8'h01);
    rd(2'd0, d); rd(2'd1, d);
    chk("R5 irq drops after clear", {7'd0, irq}, 8'h00);
    strobe(1'b1);
    wr(2'd0, 8'h01);
  endtask

  task automatic t_simple;
    logic [7:0] d;
    wr(2'd2, 8'h9C);
    chk("R6 strobe cycle 1", {7'd0, stb_out}, 8'h01);
    chk("R6 out_byte", out_byte, 8'h9C);
    @(negedge clk); chk("R6 strobe cycle 2", {7'd0, stb_out}, 8'h01);
    @(negedge clk); chk("R6 strobe ends", {7'd0, stb_out}, 8'h00);
    rd(2'd2, d); chk("R13 output reg readback", d, 8'h9C);
  endtask

  task automatic t_polarity;
    wr(2'd0, 8'h00);
    chk("R7 active-low idle", {7'd0, stb_out}, 8'h01);
    wr(2'd2, 8'h3C);
    chk("R7 active-low pulse 1", {7'd0, stb_out}, 8'h00);
    @(negedge clk); chk("R7 active-low pulse 2", {7'd0, stb_out}, 8'h00);
    @(negedge clk); chk("R7 active-low end", {7'd0, stb_out}, 8'h01);
    wr(2'd0, 8'h01);
  endtask

  task automatic t_in_lock;
    logic [7:0] d;
    wr(2'd0, 8'h11);
    chk("R8 ready after mode write", {7'd0, stb_out}, 8'h01);
    set_port(8'h44);
    strobe(1'b0);
    chk("R8 drops on edge", {7'd0, stb_out}, 8'h00);
    rd(2'd0, d); chk("R8 flag", d, 8'h91);
    chk("R8 still low after status read", {7'd0, stb_out}, 8'h00);
    rd(2'd1, d); chk("R8 held data", d, 8'h44);
    chk("R8 active after clear", {7'd0, stb_out}, 8'h01);
    strobe(1'b1);
  endtask

  task automatic t_out_lock;
    logic [7:0] d;
    wr(2'd0, 8'h19);
    chk("R9 idle after mode write", {7'd0, stb_out}, 8'h00);
    wr(2'd2, 8'h66);
    chk("R9 active on write", {7'd0, stb_out}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R9 held active", {7'd0, stb_out}, 8'h01);
    strobe(1'b0);
    chk("R9 drops on edge", {7'd0, stb_out}, 8'h00);
    rd(2'd0, d); chk("R9 flag on take", d, 8'h99);
    rd(2'd1, d);
    strobe(1'b1);
  endtask

  task automatic t_pulse;
    logic [7:0] d;
    wr(2'd0, 8'h1D);
    wr(2'd2, 8'h01);
    chk("R10 out pulse 1", {7'd0, stb_out}, 8'h01);
    @(negedge clk); chk("R10 out pulse 2", {7'd0, stb_out}, 8'h01);
    @(negedge clk); chk("R10 out pulse end", {7'd0, stb_out}, 8'h00);
    wr(2'd0, 8'h15);
    set_port(8'h0F);
    strobe(1'b0);
    chk("R10 no pulse on edge", {7'd0, stb_out}, 8'h00);
    rd(2'd0, d);
    rd(2'd1, d);
    chk("R10 in pulse 1", {7'd0, stb_out}, 8'h01);
    @(negedge clk); chk("R10 in pulse 2", {7'd0, stb_out}, 8'h01);
    @(negedge clk); chk("R10 in pulse end", {7'd0, stb_out}, 8'h00);
    strobe(1'b1);
    wr(2'd0, 8'h01);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    set_port(8'hAB);
    strobe(1'b0);
    strobe(1'b1);
    rd(2'd0, d);
    set_port(8'hCD);
    @(negedge clk); stb_in = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_addr = 2'd1; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R11 colliding read returns old byte", bus_rdata, 8'hAB);
    rd(2'd0, d); chk("R11 flag survives collision", d, 8'h81);
    rd(2'd1, d); chk("R11 new byte captured", d, 8'hCD);
    rd(2'd0, d); chk("R11 cleared afterwards", d, 8'h01);
    strobe(1'b1);
  endtask

  task automatic t_ro;
    logic [7:0] d;
    wr(2'd0, 8'h81);
    rd(2'd0, d); chk("R12 flag not settable", d, 8'h01);
    set_port(8'h3E);
    strobe(1'b0);
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R12 flag not clearable by write", d, 8'h81);
    rd(2'd1, d);
    strobe(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_fall_capture();
    t_clear_seq();
    t_rise();
    t_irq();
    t_simple();
    t_polarity();
    t_in_lock();
    t_out_lock();
    t_pulse();
    t_collide();
    t_ro();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule